// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside the fetch stage of a small 8-bit processor core. It gathers interrupt requests and offers the core one vector at a time. There are two kinds of source. Event sources set a sticky pending bit. Each bit has its own enable, and software clears it by writing a one. Condition sources have no memory and request only while their input is high and enabled. A single global enable gates all delivery. The core reports when it takes a vector, when it executes a return-from-interrupt, and when an instruction retires.

Each source has a fixed vector index, and the lowest index wins. Index 0 is the reset vector, which ranks above every source and is never produced by this block. Event sources use indices 1 to `N_EDGE`, and condition sources follow from `N_EDGE+1`. Each vector slot is two words wide. A table-select input moves the table from address zero to a boot-section base given by a parameter.

When the core takes a vector, the global enable is cleared. A handler may set it again to allow nesting. A return sets it again by itself, but nothing is delivered until one instruction has retired after that return.

Top module: `irq_vector_ctrl`

## Requirements
- R1: With defaults, event source bit k has vector index k+1 (k = 0..3), condition source bit j has index 5+j (j = 0..1), and the lowest requesting index is the one delivered. Index 0 is never delivered.
- R2: `irq_vec` equals the table base plus 2 times the index. The base is 0 when `tbl_sel` is 0 and `BOOT_BASE` (default 12'hC00) when it is 1.
- R3: `irq_req` is high exactly when the global enable is set, no return hold is active, and some pending event bit with its enable set or some asserted condition input with its enable set exists. `core_ack` while `irq_req` is low has no effect.
- R4: A vector is accepted in a cycle with `irq_req` and `core_ack` both high. Acceptance clears `gie_q` in the next cycle, and it takes priority over `core_reti` and over a software write in that cycle.
- R5: A write (`gie_we` high) loads `gie_wval` into the global enable, so a handler can re-enable to allow nesting.
- R6: A `core_reti` pulse sets `gie_q` in the next cycle.
- R7: After a `core_reti` pulse, `irq_req` stays low until a `core_retire` pulse arrives in a later cycle. A retire in the same cycle as the return does not count.
- R8: Accepting an event source clears that source's pending bit only. Accepting a condition source leaves all pending bits unchanged.
- R9: With `flag_clr_we` high, each one in `flag_clr_mask` clears the matching pending bit. Zeros leave their bits unchanged.
- R10: An event pulse sets its pending bit whatever the state of its own enable or the global enable, and the bit stays set until it is taken or cleared.
- R11: In the same cycle, an event pulse on a bit beats both a software clear and an acceptance clear of that bit.
- R12: Condition sources hold no state. A condition input that drops before its enable is set causes no request.
- R13: After reset, `flag_q` is 0, `gie_q` is 0, no return hold is active, and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| edge_evt | input | N_EDGE | Single-cycle event pulses, one per event source |
| flag_en | input | N_EDGE | Per-source enable for pending bits |
| flag_clr_we | input | 1 | Software write strobe for the clear mask |
| flag_clr_mask | input | N_EDGE | Write-one-to-clear mask |
| lvl_in | input | N_LEVEL | Condition source inputs |
| lvl_en | input | N_LEVEL | Condition source enables |
| gie_we | input | 1 | Software write strobe for the global enable |
| gie_wval | input | 1 | Value written to the global enable |
| tbl_sel | input | 1 | 0: table at address 0, 1: table at BOOT_BASE |
| core_ack | input | 1 | Core takes the offered vector |
| core_reti | input | 1 | Return-from-interrupt executed |
| core_retire | input | 1 | One instruction retired |
| irq_req | output | 1 | A vector is offered |
| irq_vec | output | ADDR_W | Offered vector address |
| flag_q | output | N_EDGE | Pending event bits |
| gie_q | output | 1 | Global enable state |

## Verification
The bench goes after the same-cycle collisions. These are an event against a software clear, an event against the acceptance clear, acceptance against a return, and a return against a retire in the same cycle. A design that ordered any of these wrongly would lose an interrupt, fail to block delivery, or deliver one instruction too early. It also checks that a pending bit raised while disabled is remembered, and that a condition input is forgotten. A wrong design would either drop the late event or fire on a stale condition. A table of mixed source patterns covers the priority order and the relocated base, where a wrong encoder or slot scale shows up as a wrong address.

// File: rtl/irq_pkg.sv
// Shared constants and helpers for the vectored interrupt controller.
// Assumes word-addressed program memory with fixed-size vector slots.
package irq_pkg;
    // Words per vector slot in the table.
    localparam int unsigned SLOT_WORDS = 2;

    // Offset in words of a vector index from the table base.
    function automatic int unsigned slot_offset(input int unsigned idx);
        return idx * SLOT_WORDS;
    endfunction
endpackage

// File: rtl/irq_flag_bank.sv
// Sticky pending bits for event sources.
// Set by event pulses, cleared by software write-one or by acceptance.
// Assumes event pulses are synchronous to clk; a set beats any clear.
module irq_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         sw_we_i,
    input  logic [N-1:0] sw_mask_i,
    input  logic [N-1:0] hw_clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] clr_all;

    // Combine software and acceptance clears.
    always_comb clr_all = (sw_we_i ? sw_mask_i : '0) | hw_clr_i;

    // Update the pending bits; a set has precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= '0;
        else        flag_o <= set_i | (flag_o & ~clr_all);
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Fixed-priority encoder: the lowest set bit wins.
// Assumes N >= 1; idx_o is the position of the winner, 0 when none.
module irq_prio_enc #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    logic [N:0]   seen;
    logic [N-1:0] grant;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign seen[i+1] = seen[i] | req_i[i];
        assign grant[i]  = req_i[i] & ~seen[i];
    end

    assign any_o = seen[N];

    // Fold the one-hot grant into a binary index.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx_o = idx_o | IW'(i);
        end
    end
endmodule

// File: rtl/irq_gate.sv
// Global enable and return hold.
// Acceptance clears the enable; a return sets it; software may write it.
// After a return, the hold blocks delivery until a later retire pulse.
module irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic reti_i,
    input  logic retire_i,
    input  logic sw_we_i,
    input  logic sw_val_i,
    output logic gie_o,
    output logic hold_o
);
    // Global enable: acceptance first, then return, then software.
    always_ff @(posedge clk) begin
        if (!rst_n)        gie_o <= 1'b0;
        else if (accept_i) gie_o <= 1'b0;
        else if (reti_i)   gie_o <= 1'b1;
        else if (sw_we_i)  gie_o <= sw_val_i;
    end

    // Return hold: set by a return, released by a retire in a later cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_o <= 1'b0;
        else if (reti_i)   hold_o <= 1'b1;
        else if (retire_i) hold_o <= 1'b0;
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Prioritized vectored interrupt controller (top).
// Event sources take indices 1..N_EDGE and condition sources the ones after.
// Index 0 is reserved for reset. The vector is base + SLOT_WORDS * index.
// Assumes the core raises core_ack only in a cycle where it can branch.
module irq_vector_ctrl #(
    parameter int                N_EDGE    = 4,
    parameter int                N_LEVEL   = 2,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 12'hC00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_EDGE-1:0]  edge_evt,
    input  logic [N_EDGE-1:0]  flag_en,
    input  logic               flag_clr_we,
    input  logic [N_EDGE-1:0]  flag_clr_mask,
    input  logic [N_LEVEL-1:0] lvl_in,
    input  logic [N_LEVEL-1:0] lvl_en,
    input  logic               gie_we,
    input  logic               gie_wval,
    input  logic               tbl_sel,
    input  logic               core_ack,
    input  logic               core_reti,
    input  logic               core_retire,
    output logic               irq_req,
    output logic [ADDR_W-1:0]  irq_vec,
    output logic [N_EDGE-1:0]  flag_q,
    output logic               gie_q
);
    localparam int NSRC = N_EDGE + N_LEVEL;
    localparam int IW   = $clog2(NSRC + 1);

    logic [NSRC-1:0]   src_req;
    logic              any_req;
    logic [IW-1:0]     win_pos;
    logic [IW-1:0]     win_idx;
    logic              hold;
    logic              accept;
    logic [N_EDGE-1:0] hw_clr;
    logic [ADDR_W-1:0] tbl_base;

    irq_flag_bank #(.N(N_EDGE)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (edge_evt),
        .sw_we_i   (flag_clr_we),
        .sw_mask_i (flag_clr_mask),
        .hw_clr_i  (hw_clr),
        .flag_o    (flag_q)
    );

    // Enabled requests, event sources in the low bits.
    always_comb src_req = {lvl_in & lvl_en, flag_q & flag_en};

    irq_prio_enc #(.N(NSRC), .IW(IW)) u_enc (
        .req_i (src_req),
        .any_o (any_req),
        .idx_o (win_pos)
    );

    irq_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .reti_i   (core_reti),
        .retire_i (core_retire),
        .sw_we_i  (gie_we),
        .sw_val_i (gie_wval),
        .gie_o    (gie_q),
        .hold_o   (hold)
    );

    // Offer a vector only when enabled and not in the return hold.
    always_comb begin
        irq_req = any_req & gie_q & ~hold;
        accept  = irq_req & core_ack;
    end

    // Acceptance clears the winning pending bit.
    for (genvar i = 0; i < N_EDGE; i++) begin : g_hwclr
        assign hw_clr[i] = accept && (win_pos == IW'(i));
    end

    // Vector address from the table base and the winner's index.
    always_comb begin
        win_idx  = win_pos + IW'(1);
        tbl_base = tbl_sel ? BOOT_BASE : '0;
        irq_vec  = tbl_base + ADDR_W'(irq_pkg::slot_offset(int'(win_idx)));
    end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
// Assertion checker for irq_vector_ctrl, bound to every instance.
module irq_vector_ctrl_chk #(
    parameter int N_EDGE = 4,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_EDGE-1:0] edge_evt,
    input logic              core_ack,
    input logic              core_reti,
    input logic              irq_req,
    input logic [ADDR_W-1:0] irq_vec,
    input logic [N_EDGE-1:0] flag_q,
    input logic              gie_q
);
    // R4
    accept_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && core_ack) |=> !gie_q);

    // R6
    reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_reti && !(irq_req && core_ack)) |=> gie_q);

    // R7
    reti_holds_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_reti |=> !irq_req);

    // R3
    req_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gie_q);

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_evt) |=> ((flag_q & $past(edge_evt)) == $past(edge_evt)));

    // R2
    vec_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[0] == 1'b0));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N_EDGE(N_EDGE), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_evt  (edge_evt),
    .core_ack  (core_ack),
    .core_reti (core_reti),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .flag_q    (flag_q),
    .gie_q     (gie_q)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
    localparam logic [11:0] BOOT = 12'hC00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  edge_evt = '0, flag_en = '0, flag_clr_mask = '0;
    logic        flag_clr_we = 1'b0;
    logic [1:0]  lvl_in = '0, lvl_en = '0;
    logic        gie_we = 1'b0, gie_wval = 1'b0, tbl_sel = 1'b0;
    logic        core_ack = 1'b0, core_reti = 1'b0, core_retire = 1'b0;
    logic        irq_req;
    logic [11:0] irq_vec;
    logic [3:0]  flag_q;
    logic        gie_q;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt), .flag_en(flag_en),
        .flag_clr_we(flag_clr_we), .flag_clr_mask(flag_clr_mask),
        .lvl_in(lvl_in), .lvl_en(lvl_en), .gie_we(gie_we), .gie_wval(gie_wval),
        .tbl_sel(tbl_sel), .core_ack(core_ack), .core_reti(core_reti),
        .core_retire(core_retire), .irq_req(irq_req), .irq_vec(irq_vec),
        .flag_q(flag_q), .gie_q(gie_q)
    );

    // Table entry: {event, flag enable, condition, condition enable, table select, expected req, expected index}
    localparam int NV = 8;
    localparam logic [19:0] VEC_TBL [NV] = '{
        {4'b0001, 4'b0001, 2'b00, 2'b00, 1'b0, 1'b1, 3'd1},
        {4'b1010, 4'b1010, 2'b00, 2'b00, 1'b0, 1'b1, 3'd2},
        {4'b1000, 4'b1000, 2'b00, 2'b00, 1'b0, 1'b1, 3'd4},
        {4'b0000, 4'b0000, 2'b01, 2'b01, 1'b0, 1'b1, 3'd5},
        {4'b0100, 4'b0000, 2'b10, 2'b10, 1'b0, 1'b1, 3'd6},
        {4'b0001, 4'b0001, 2'b11, 2'b11, 1'b1, 1'b1, 3'd1},
        {4'b0000, 4'b0000, 2'b10, 2'b01, 1'b0, 1'b0, 3'd0},
        {4'b0000, 4'b0000, 2'b11, 2'b11, 1'b1, 1'b1, 3'd5}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    function automatic logic [11:0] exp_vec(input bit sel, input int idx);
        return (sel ? BOOT : 12'h000) + 12'(2 * idx);
    endfunction

    task automatic set_gie(input bit v);
        gie_we = 1'b1; gie_wval = v;
        tick();
        gie_we = 1'b0;
    endtask

    task automatic clear_flags();
        flag_clr_we = 1'b1; flag_clr_mask = 4'hF;
        tick();
        flag_clr_we = 1'b0; flag_clr_mask = 4'h0;
    endtask

    task automatic pulse_evt(input logic [3:0] e);
        edge_evt = e;
        tick();
        edge_evt = '0;
    endtask

    task automatic accept_one();
        core_ack = 1'b1;
        tick();
        core_ack = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick(); settle();
        // R13 reset state
        check(irq_req == 1'b0, "R13 req after reset", 32'(irq_req), 0);
        check(gie_q == 1'b0, "R13 gie after reset", 32'(gie_q), 0);
        check(flag_q == 4'h0, "R13 flags after reset", 32'(flag_q), 0);

        // Table walk: R1 priority, R2 vector, R3 request, R12 condition sources
        for (int k = 0; k < NV; k++) begin
            logic [3:0] ev, en;
            logic [1:0] lv, le;
            logic       sel, xr;
            logic [2:0] xi;
            {ev, en, lv, le, sel, xr, xi} = VEC_TBL[k];
            flag_en = '0; lvl_in = '0; lvl_en = '0;
            set_gie(1'b1);
            clear_flags();
            pulse_evt(ev);
            flag_en = en; lvl_in = lv; lvl_en = le; tbl_sel = sel;
            settle();
            check(irq_req == xr, $sformatf("R3 table %0d req", k), 32'(irq_req), 32'(xr));
            if (xr)
                check(irq_vec == exp_vec(sel, int'(xi)),
                      $sformatf("R1 R2 table %0d vector", k), 32'(irq_vec), 32'(exp_vec(sel, int'(xi))));
            tick();
        end
        lvl_in = '0; lvl_en = '0; tbl_sel = 1'b0; flag_en = '0;
        clear_flags();

        // R10: latched while own enable and global enable are off
        pulse_evt(4'b0100); settle();
        check(flag_q == 4'b0100 && !irq_req, "R10 latched with own enable off", 32'({irq_req, flag_q}), 32'h4);
        set_gie(1'b0);
        pulse_evt(4'b0001);
        flag_en = 4'hF; settle();
        check(flag_q == 4'b0101 && !irq_req, "R10 latched with global off", 32'({irq_req, flag_q}), 32'h5);
        set_gie(1'b1); settle();
        check(irq_req && irq_vec == 12'd2, "R1 lowest pending wins", 32'({irq_req, irq_vec}), 32'h1002);

        // R4 R8: acceptance clears global enable and only the winner's bit
        accept_one(); settle();
        check(!gie_q && !irq_req, "R4 accept clears gie", 32'({irq_req, gie_q}), 0);
        check(flag_q == 4'b0100, "R8 winner bit cleared", 32'(flag_q), 32'h4);

        // R5: nesting by software write
        set_gie(1'b1); settle();
        check(gie_q && irq_req && irq_vec == 12'd6, "R5 nested request", 32'({gie_q, irq_req, irq_vec}), 32'h3006);
        accept_one();

        // R6 R7: return sets gie, delivery held until a later retire
        pulse_evt(4'b1000);
        core_reti = 1'b1; tick(); core_reti = 1'b0; settle();
        check(gie_q, "R6 return sets gie", 32'(gie_q), 1);
        check(!irq_req, "R7 held after return", 32'(irq_req), 0);
        tick(); settle();
        check(!irq_req, "R7 still held without retire", 32'(irq_req), 0);
        core_retire = 1'b1; tick(); core_retire = 1'b0; settle();
        check(irq_req && irq_vec == 12'd8, "R7 released by retire", 32'({irq_req, irq_vec}), 32'h1008);
        accept_one();

        // R7: retire in the same cycle as the return does not count
        pulse_evt(4'b0010);
        core_reti = 1'b1; core_retire = 1'b1; tick();
        core_reti = 1'b0; core_retire = 1'b0; settle();
        check(gie_q && !irq_req, "R7 same-cycle retire ignored", 32'({gie_q, irq_req}), 32'h2);
        core_retire = 1'b1; tick(); core_retire = 1'b0; settle();
        check(irq_req && irq_vec == 12'd4, "R7 later retire releases", 32'({irq_req, irq_vec}), 32'h1004);
        accept_one();

        // R9: write-one clears, zeros have no effect
        pulse_evt(4'hF);
        flag_clr_we = 1'b1; flag_clr_mask = 4'b0000; tick(); settle();
        check(flag_q == 4'hF, "R9 zero mask no effect", 32'(flag_q), 32'hF);
        flag_clr_mask = 4'b0101; tick(); flag_clr_we = 1'b0; flag_clr_mask = '0; settle();
        check(flag_q == 4'b1010, "R9 ones clear", 32'(flag_q), 32'hA);

        // R11: set beats software clear in the same cycle
        edge_evt = 4'b0011; flag_clr_we = 1'b1; flag_clr_mask = 4'b0011; tick();
        edge_evt = '0; flag_clr_we = 1'b0; flag_clr_mask = '0; settle();
        check(flag_q == 4'b1011, "R11 set beats software clear", 32'(flag_q), 32'hB);

        // R11: set beats acceptance clear in the same cycle
        set_gie(1'b1); settle();
        check(irq_req && irq_vec == 12'd2, "R1 bit0 offered", 32'({irq_req, irq_vec}), 32'h1002);
        core_ack = 1'b1; edge_evt = 4'b0001; tick();
        core_ack = 1'b0; edge_evt = '0; settle();
        check(flag_q == 4'b1011 && !gie_q, "R11 set beats acceptance clear", 32'({gie_q, flag_q}), 32'hB);

        // R12: condition dropped before enable gives nothing
        clear_flags();
        set_gie(1'b1);
        lvl_in = 2'b01; lvl_en = 2'b00; tick();
        lvl_in = 2'b00; lvl_en = 2'b11; settle();
        check(!irq_req, "R12 dropped condition forgotten", 32'(irq_req), 0);
        lvl_in = 2'b10; settle();
        check(irq_req && irq_vec == 12'd12, "R12 live condition requests", 32'({irq_req, irq_vec}), 32'h100C);
        accept_one(); settle();
        check(!gie_q && flag_q == 4'h0, "R8 condition accept leaves flags", 32'({gie_q, flag_q}), 0);
        lvl_in = '0;

        // R3: acknowledge without a request is ignored
        set_gie(1'b1);
        core_ack = 1'b1; tick(); core_ack = 1'b0; settle();
        check(gie_q, "R3 stray acknowledge ignored", 32'(gie_q), 1);

        // R4: acceptance beats a return in the same cycle
        lvl_in = 2'b01; settle();
        core_ack = 1'b1; core_reti = 1'b1; tick();
        core_ack = 1'b0; core_reti = 1'b0; settle();
        check(!gie_q, "R4 accept beats return", 32'(gie_q), 0);
        lvl_in = '0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule